// File: doc/BRIEF.md
# Phase-Frequency Detector with Digital Lock Filter

The block compares two divided clock-like signals: the feedback from the divided oscillator and the divided reference. It acts only on their rising edges. Both signals pass through two-stage synchronizers on a fast sampling clock. Edges are found by comparing each synchronized sample with the sample before it. When the feedback edge comes first, an active-low down pulse opens and holds until the reference edge arrives. When the reference edge comes first, an active-low up pulse opens instead. Each pulse therefore lasts as many sampling cycles as the two edges are apart. If both edges land in the same sampling cycle, no pulse is produced. At rest both outputs sit high.

An activity flag is the NAND of the two active-low outputs, so it is high while either correction is in progress. A digital filter stands in for an external integrating capacitor. For each reference period it totals the cycles in which the activity flag was high. It raises the lock flag after a run of quiet periods. It drops the lock flag as soon as any period exceeds the activity limit.

Top module: `pfd_lock_det`

## Requirements
- R1: While reset is asserted and right after it, `dn_n` and `up_n` are 1, `active` is 0 and `locked` is 0.
- R2: When the feedback rising edge precedes the reference rising edge by k sampling cycles (k >= 1), `dn_n` is low for exactly k cycles and `up_n` stays high.
- R3: When the reference rising edge precedes the feedback rising edge by k sampling cycles (k >= 1), `up_n` is low for exactly k cycles and `dn_n` stays high.
- R4: Rising edges on both inputs in the same sampling cycle produce no pulse on either output.
- R5: `dn_n` and `up_n` are never low in the same cycle.
- R6: `active` equals the NAND of `dn_n` and `up_n` in every cycle.
- R7: With the feedback frequency above the reference frequency only `dn_n` pulses. With it below, only `up_n` pulses.
- R8: The activity count of a reference period covers the cycles from just after one reference rising edge up to and including the next. `locked` rises once LOCK_PERIODS (16) consecutive complete periods each have an activity count of at most MAX_ACTIVE (2). The partial period before the first reference edge after reset does not count toward this.
- R9: As soon as the running activity count of the current period exceeds MAX_ACTIVE, `locked` is 0 on the following cycle and the quiet-period count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Divided feedback signal, asynchronous |
| ref_in | input | 1 | Divided reference signal, asynchronous |
| dn_n | output | 1 | Active-low command to lower the oscillator frequency |
| up_n | output | 1 | Active-low command to raise the oscillator frequency |
| active | output | 1 | High while either correction pulse is low |
| locked | output | 1 | Filtered lock indication |

## Verification
The two inputs run at equal period while the feedback phase is swept from six cycles ahead of the reference to six cycles behind. In every setting the low-cycle totals of both outputs are compared with the arithmetic expectation. This sweep separates the sign of the correction, its exact width and the zero-offset case. The same settings also exercise the lock threshold, because offsets of up to two cycles must lock and offsets of three or more must not. Two frequency-mismatch runs, one with a faster and one with a slower feedback signal, confirm that only the matching correction direction appears. A switch from a locked zero-offset setting to a large offset shows how quickly lock is lost.

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int SYNC_STAGES  = 2,
  parameter int LOCK_PERIODS = 16,
  parameter int MAX_ACTIVE   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fb_in,
  input  logic ref_in,
  output logic dn_n,
  output logic up_n,
  output logic active,
  output logic locked
);
  localparam int ACT_SAT = MAX_ACTIVE + 1;
  localparam int ACT_W   = $clog2(ACT_SAT + 1);
  localparam int GOOD_W  = $clog2(LOCK_PERIODS + 1);

  logic [SYNC_STAGES:0] fb_sh, ref_sh;
  logic fb_rise, ref_rise;
  logic dn_flag, up_flag, dn_set, up_set;
  logic [ACT_W-1:0] act_cnt, act_sum;
  logic [GOOD_W-1:0] good_cnt;
  logic ref_seen, too_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_sh  <= '0;
      ref_sh <= '0;
    end else begin
      fb_sh  <= {fb_sh[SYNC_STAGES-1:0], fb_in};
      ref_sh <= {ref_sh[SYNC_STAGES-1:0], ref_in};
    end
  end

  assign fb_rise  = fb_sh[SYNC_STAGES-1]  & ~fb_sh[SYNC_STAGES];
  assign ref_rise = ref_sh[SYNC_STAGES-1] & ~ref_sh[SYNC_STAGES];

  assign dn_set = dn_flag | fb_rise;
  assign up_set = up_flag | ref_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dn_flag <= 1'b0;
      up_flag <= 1'b0;
    end else if (dn_set && up_set) begin
      dn_flag <= 1'b0;
      up_flag <= 1'b0;
    end else begin
      dn_flag <= dn_set;
      up_flag <= up_set;
    end
  end

  assign dn_n   = ~dn_flag;
  assign up_n   = ~up_flag;
  assign active = dn_flag | up_flag;

  assign act_sum  = (act_cnt == ACT_W'(ACT_SAT)) ? act_cnt : act_cnt + ACT_W'(active);
  assign too_busy = act_sum > ACT_W'(MAX_ACTIVE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_cnt  <= '0;
      good_cnt <= '0;
      ref_seen <= 1'b0;
    end else begin
      act_cnt <= ref_rise ? '0 : act_sum;
      if (ref_rise) ref_seen <= 1'b1;
      if (too_busy)
        good_cnt <= '0;
      else if (ref_rise && ref_seen && good_cnt != GOOD_W'(LOCK_PERIODS))
        good_cnt <= good_cnt + 1'b1;
    end
  end

  assign locked = good_cnt == GOOD_W'(LOCK_PERIODS);
endmodule

module pfd_lock_det_chk #(
  parameter int ACT_W      = 2,
  parameter int MAX_ACTIVE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic dn_n,
  input logic up_n,
  input logic active,
  input logic locked,
  input logic fb_rise,
  input logic ref_rise,
  input logic [ACT_W-1:0] act_sum
);
  AST_NEVER_BOTH_LOW: assert property (@(posedge clk) disable iff (!rst_n) (dn_n || up_n)); // R5
  AST_ACTIVE_IS_NAND: assert property (@(posedge clk) disable iff (!rst_n) active == !(dn_n && up_n)); // R6
  AST_DN_FROM_FB_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(dn_n) |-> $past(fb_rise)); // R2
  AST_UP_FROM_REF_EDGE: assert property (@(posedge clk) disable iff (!rst_n) $fell(up_n) |-> $past(ref_rise)); // R3
  AST_DN_ENDS_ON_REF: assert property (@(posedge clk) disable iff (!rst_n) (!dn_n && ref_rise) |=> dn_n); // R2
  AST_UP_ENDS_ON_FB: assert property (@(posedge clk) disable iff (!rst_n) (!up_n && fb_rise) |=> up_n); // R3
  AST_COINCIDENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (fb_rise && ref_rise && dn_n && up_n) |=> (dn_n && up_n)); // R4
  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (act_sum > ACT_W'(MAX_ACTIVE)) |=> !locked); // R9
endmodule

bind pfd_lock_det pfd_lock_det_chk #(.ACT_W(ACT_W), .MAX_ACTIVE(MAX_ACTIVE)) chk_i (
  .clk(clk), .rst_n(rst_n), .dn_n(dn_n), .up_n(up_n), .active(active),
  .locked(locked), .fb_rise(fb_rise), .ref_rise(ref_rise), .act_sum(act_sum)
);

// File: tb/pfd_lock_det_tb.sv
module pfd_lock_det_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fb_in = 1'b0, ref_in = 1'b0;
  logic dn_n, up_n, active, locked;

  int checks = 0, errors = 0;
  int ref_per = 24, fb_per = 24;
  int ref_ph = 0, fb_ph = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pfd_lock_det dut_i (
    .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ref_in(ref_in),
    .dn_n(dn_n), .up_n(up_n), .active(active), .locked(locked)
  );

  initial forever begin
    @(negedge clk);
    ref_ph = (ref_ph + 1) % ref_per;
    fb_ph  = (fb_ph + 1) % fb_per;
    ref_in = ref_ph < ref_per / 2;
    fb_in  = fb_ph < fb_per / 2;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_lag(input int k);
    @(posedge clk);
    fb_per = 24;
    ref_per = 24;
    fb_ph = (ref_ph - k + 48) % 24;
  endtask

  task automatic measure(input int cycles, output int dn_lo, output int up_lo,
                         output int both_lo, output int nand_bad);
    dn_lo = 0; up_lo = 0; both_lo = 0; nand_bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!dn_n) dn_lo++;
      if (!up_n) up_lo++;
      if (!dn_n && !up_n) both_lo++;
      if (active != !(dn_n && up_n)) nand_bad++;
    end
  endtask

  task automatic align();
    do @(negedge clk); while (ref_ph != 12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int dl, ul, bl, nb, exp_dn, exp_up;
    repeat (5) @(negedge clk);
    check(dn_n === 1'b1 && up_n === 1'b1, "R1 outputs in reset", {dn_n, up_n}, 3);
    check(active === 1'b0 && locked === 1'b0, "R1 flags in reset", {active, locked}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(dn_n === 1'b1 && up_n === 1'b1 && active === 1'b0 && locked === 1'b0,
          "R1 after reset", {dn_n, up_n, active, locked}, 4'b1100);

    set_lag(0);
    repeat (10 * 24) @(negedge clk);
    check(locked === 1'b0, "R8 not locked early", locked, 0);
    repeat (14 * 24) @(negedge clk);
    check(locked === 1'b1, "R8 lock at zero offset", locked, 1);

    for (int k = -6; k <= 6; k++) begin
      set_lag(k);
      repeat (3 * 24) @(negedge clk);
      align();
      measure(8 * 24, dl, ul, bl, nb);
      exp_dn = (k < 0) ? -8 * k : 0;
      exp_up = (k > 0) ? 8 * k : 0;
      if (k < 0) check(dl == exp_dn, "R2 down width", dl, exp_dn);
      else if (k > 0) check(ul == exp_up, "R3 up width", ul, exp_up);
      else check(dl == 0 && ul == 0, "R4 coincident edges", dl + ul, 0);
      if (k < 0) check(ul == 0, "R2 up idle", ul, 0);
      if (k > 0) check(dl == 0, "R3 down idle", dl, 0);
      check(bl == 0, "R5 never both low", bl, 0);
      check(nb == 0, "R6 active is nand", nb, 0);
      repeat (20 * 24) @(negedge clk);
      check(locked === ((k >= -2 && k <= 2) ? 1'b1 : 1'b0), "R8 lock vs offset",
            locked, (k >= -2 && k <= 2) ? 1 : 0);
    end

    set_lag(0);
    repeat (30 * 24) @(negedge clk);
    check(locked === 1'b1, "R9 relock before drop", locked, 1);
    set_lag(4);
    repeat (2 * 24) @(negedge clk);
    check(locked === 1'b0, "R9 lock lost", locked, 0);

    @(posedge clk);
    fb_per = 20;
    repeat (5 * 24) @(negedge clk);
    measure(12 * 24, dl, ul, bl, nb);
    check(ul == 0, "R7 fast feedback no up", ul, 0);
    check(dl > 0, "R7 fast feedback down", dl, 1);

    @(posedge clk);
    fb_per = 30;
    repeat (5 * 30) @(negedge clk);
    measure(12 * 30, dl, ul, bl, nb);
    check(dl == 0, "R7 slow feedback no down", dl, 0);
    check(ul > 0, "R7 slow feedback up", ul, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule